// File: doc/BRIEF.md
# Microcontroller Bus to Buffer-RAM Bridge

This block sits between an 8-bit microcontroller's multiplexed external bus and a port on a shared buffer-memory arbiter. It captures the low address byte from the multiplexed lines when the address-latch strobe falls. It joins that byte with the high address byte and checks whether the 16-bit address lies in the buffer-RAM window, which starts at `WIN_BASE`, by default 0xC000. For an access in the window it issues a single-byte request on a req/ack memory port. While a confirmed access is outstanding it asserts a clock-hold output, which stops the microcontroller.

A mode bit selects one of two start policies.

- **Eager policy (bit = 1):** the memory read starts as soon as the address latch falls on a window address, before the microcontroller shows whether a data access follows. If another memory user is active at that moment, the bridge pulses an abort to it.
- **Confirmed policy (bit = 0):** the request starts only on a read-strobe or write-strobe fall, and only while the program-fetch strobe is high.

All strobe inputs are registered on the system clock, and edges are found by comparing each input with its registered copy.

Top module: `mcu_ram_bridge`

## Requirements
- R1: After reset, mem_req_o, mem_abort_o, mcu_clk_hold_o and mcu_ad_oe_o are all 0.
- R2: mem_addr_o equals {mcu_addr_hi_i, mcu_ad_i}, both sampled at the clock edge where the address latch is seen falling. While mem_req_o is high and mem_ack_i is low, mem_addr_o stays unchanged.
- R3: In eager mode, an address latch on an address below WIN_BASE raises no request. A read that follows it with the fetch strobe low (a program fetch) is not served and is not stalled.
- R4: In eager mode, an address latch on an address at or above WIN_BASE raises mem_req_o with mem_we_o=0 one clock after the fall is seen, before any read or write strobe. If the eager read has completed when the read strobe falls, the buffered byte is driven with no new request.
- R5: mem_abort_o is a one-cycle pulse. It coincides with the rising mem_req_o of an eager read, and it fires only if mem_other_busy_i was high when that read was launched.
- R6: In confirmed mode, the address latch alone raises no request. A read-strobe or write-strobe fall with the fetch strobe high and a window address raises mem_req_o one clock later. Addresses below WIN_BASE raise no request.
- R7: In confirmed mode, a read-strobe fall while the fetch strobe is low raises no request.
- R8: mcu_clk_hold_o is high from one clock after a confirmed strobe fall while the needed memory transfer is outstanding. It drops after the final mem_ack_i. mcu_clk_hold_o is only ever high while mem_req_o is high.
- R9: For a read, mcu_ad_oe_o is high and mcu_ad_o carries the byte returned by memory until the clock after the read strobe goes high.
- R10: For a write, mem_we_o=1 and mem_wdata_o holds the mcu_ad_i byte captured at the write-strobe fall. In eager mode, this write request follows the completed eager read.
- R11: An eager read that no strobe follows never asserts the hold. Its byte is discarded on the next address latch.
- R12: The mode bit is sampled only while the bridge is idle. A change made while an eager read's byte is pending does not alter how that access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_mode_i | input | 1 | Start policy: 1 eager, 0 confirmed |
| mcu_alatch_i | input | 1 | Address-latch strobe, active high |
| mcu_fetch_n_i | input | 1 | Program-fetch strobe, active low |
| mcu_rdstb_n_i | input | 1 | Read strobe, active low |
| mcu_wrstb_n_i | input | 1 | Write strobe, active low |
| mcu_addr_hi_i | input | 8 | High address byte |
| mcu_ad_i | input | 8 | Multiplexed address/data lines, input side |
| mcu_ad_o | output | 8 | Read data driven toward the microcontroller |
| mcu_ad_oe_o | output | 1 | Output enable for mcu_ad_o |
| mcu_clk_hold_o | output | 1 | Stops the microcontroller clock |
| mem_req_o | output | 1 | Memory request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid with mem_ack_i |
| mem_ack_i | input | 1 | One-cycle completion from memory |
| mem_other_busy_i | input | 1 | Another buffer user is active |
| mem_abort_o | output | 1 | One-cycle preempt pulse to other users |

## Verification
In eager mode, the completion of the eager read can land in the same cycle as, or after, the read or write strobe that confirms the access. The bench provokes this by dropping a strobe while the eager request is still waiting for acknowledge. It then checks that the hold rises, that a write is chained as a second request, and that the hold falls only after the final acknowledge. The launch of an eager read can also coincide with another user being busy. The bench drives that busy input high during a latch and judges the abort pulse by its single-cycle width and its alignment with the request edge.

// File: rtl/mcub_pkg.sv
package mcub_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPEC,
        ST_PREF,
        ST_XFER,
        ST_DRIVE
    } bst_e;

    typedef struct packed {
        bst_e              st;
        logic              fast;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rbuf;
        logic              rd_pend;
        logic              wr_pend;
        logic              abort;
    } bctl_s;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        return a >= base;
    endfunction
endpackage

// File: rtl/mcub_strobe_edge.sv
module mcub_strobe_edge #(
    parameter int         N       = 4,
    parameter logic [3:0] RST_VAL = 4'b1110
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] lvl_d, lvl_q;

    always_comb lvl_d = raw_i;

    for (genvar i = 0; i < N; i++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[i] <= RST_VAL[i];
            else        lvl_q[i] <= lvl_d[i];
        end
        assign fall_o[i] = lvl_q[i] & ~raw_i[i];
    end
endmodule

// File: rtl/mcub_addr_decode.sv
module mcub_addr_decode
    import mcub_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000
) (
    input  logic [7:0]        hi_i,
    input  logic [7:0]        lo_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              hit_o
);
    always_comb begin
        addr_o = {hi_i, lo_i};
        hit_o  = in_window(addr_o, WIN_BASE);
    end
endmodule

// File: rtl/mcub_ctl.sv
module mcub_ctl
    import mcub_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode_i,
    input  logic              ale_fall_i,
    input  logic              rd_fall_i,
    input  logic              wr_fall_i,
    input  logic              fetch_n_i,
    input  logic              rd_n_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic              cur_hit_i,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic              other_busy_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_abort_o,
    output logic              hold_o,
    output logic              ad_oe_o,
    output logic [DATA_W-1:0] ad_o
);
    bctl_s r_q, r_d;
    logic  mode;
    logic  free;

    always_comb begin
        r_d      = r_q;
        r_d.abort = 1'b0;
        free     = (r_q.st == ST_IDLE) || (r_q.st == ST_PREF);
        mode     = (r_q.st == ST_IDLE) ? fast_mode_i : r_q.fast;
        if (r_q.st == ST_IDLE) r_d.fast = fast_mode_i;

        if (free && ale_fall_i) begin
            r_d.addr    = cur_addr_i;
            r_d.rd_pend = 1'b0;
            r_d.wr_pend = 1'b0;
            if (mode && cur_hit_i) begin
                r_d.st    = ST_SPEC;
                r_d.we    = 1'b0;
                r_d.abort = other_busy_i;
            end else begin
                r_d.st = ST_IDLE;
            end
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!mode && fetch_n_i && in_window(r_q.addr, WIN_BASE)
                        && (rd_fall_i || wr_fall_i)) begin
                        r_d.st    = ST_XFER;
                        r_d.we    = wr_fall_i;
                        r_d.wdata = ad_i;
                    end
                end
                ST_PREF: begin
                    if (rd_fall_i) begin
                        r_d.st = ST_DRIVE;
                    end else if (wr_fall_i) begin
                        r_d.st    = ST_XFER;
                        r_d.we    = 1'b1;
                        r_d.wdata = ad_i;
                    end
                end
                ST_SPEC: begin
                    if (rd_fall_i) r_d.rd_pend = 1'b1;
                    if (wr_fall_i) begin
                        r_d.wr_pend = 1'b1;
                        r_d.wdata   = ad_i;
                    end
                    if (mem_ack_i) begin
                        r_d.rbuf    = mem_rdata_i;
                        r_d.rd_pend = 1'b0;
                        r_d.wr_pend = 1'b0;
                        if (r_q.wr_pend || wr_fall_i) begin
                            r_d.st = ST_XFER;
                            r_d.we = 1'b1;
                        end else if (r_q.rd_pend || rd_fall_i) begin
                            r_d.st = ST_DRIVE;
                        end else begin
                            r_d.st = ST_PREF;
                        end
                    end
                end
                ST_XFER: begin
                    if (mem_ack_i) begin
                        if (r_q.we) r_d.st = ST_IDLE;
                        else begin
                            r_d.rbuf = mem_rdata_i;
                            r_d.st   = ST_DRIVE;
                        end
                    end
                end
                ST_DRIVE: begin
                    if (rd_n_i) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, fast: 1'b0, addr: '0, we: 1'b0, wdata: '0,
                     rbuf: '0, rd_pend: 1'b0, wr_pend: 1'b0, abort: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req_o   = (r_q.st == ST_SPEC) || (r_q.st == ST_XFER);
        mem_addr_o  = r_q.addr;
        mem_we_o    = r_q.we;
        mem_wdata_o = r_q.wdata;
        mem_abort_o = r_q.abort;
        hold_o      = (r_q.st == ST_XFER) ||
                      ((r_q.st == ST_SPEC) && (r_q.rd_pend || r_q.wr_pend));
        ad_oe_o     = (r_q.st == ST_DRIVE);
        ad_o        = r_q.rbuf;
    end
endmodule

// File: rtl/mcu_ram_bridge.sv
module mcu_ram_bridge
    import mcub_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_mode_i,
    input  logic        mcu_alatch_i,
    input  logic        mcu_fetch_n_i,
    input  logic        mcu_rdstb_n_i,
    input  logic        mcu_wrstb_n_i,
    input  logic [7:0]  mcu_addr_hi_i,
    input  logic [7:0]  mcu_ad_i,
    output logic [7:0]  mcu_ad_o,
    output logic        mcu_ad_oe_o,
    output logic        mcu_clk_hold_o,
    output logic        mem_req_o,
    output logic [15:0] mem_addr_o,
    output logic        mem_we_o,
    output logic [7:0]  mem_wdata_o,
    input  logic [7:0]  mem_rdata_i,
    input  logic        mem_ack_i,
    input  logic        mem_other_busy_i,
    output logic        mem_abort_o
);
    logic [3:0]        falls;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_hit;

    // bit order: 0 latch, 1 read, 2 write, 3 fetch
    mcub_strobe_edge #(.N(4), .RST_VAL(4'b1110)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({mcu_fetch_n_i, mcu_wrstb_n_i, mcu_rdstb_n_i, mcu_alatch_i}),
        .fall_o (falls)
    );

    mcub_addr_decode #(.WIN_BASE(WIN_BASE)) u_dec (
        .hi_i   (mcu_addr_hi_i),
        .lo_i   (mcu_ad_i),
        .addr_o (cur_addr),
        .hit_o  (cur_hit)
    );

    mcub_ctl #(.WIN_BASE(WIN_BASE)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fast_mode_i  (fast_mode_i),
        .ale_fall_i   (falls[0]),
        .rd_fall_i    (falls[1]),
        .wr_fall_i    (falls[2]),
        .fetch_n_i    (mcu_fetch_n_i & ~falls[3]),
        .rd_n_i       (mcu_rdstb_n_i),
        .cur_addr_i   (cur_addr),
        .cur_hit_i    (cur_hit),
        .ad_i         (mcu_ad_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_ack_i    (mem_ack_i),
        .other_busy_i (mem_other_busy_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_we_o     (mem_we_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_abort_o  (mem_abort_o),
        .hold_o       (mcu_clk_hold_o),
        .ad_oe_o      (mcu_ad_oe_o),
        .ad_o         (mcu_ad_o)
    );
endmodule

// File: rtl/mcu_ram_bridge_chk.sv
module mcu_ram_bridge_chk #(
    parameter logic [15:0] WIN_BASE = 16'hC000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mcu_rdstb_n_i,
    input logic        mcu_ad_oe_o,
    input logic        mcu_clk_hold_o,
    input logic        mem_req_o,
    input logic [15:0] mem_addr_o,
    input logic        mem_we_o,
    input logic        mem_ack_i,
    input logic        mem_abort_o
);
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r3_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o >= WIN_BASE));

    a_r5_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort_o |=> !mem_abort_o);

    a_r5_abort_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort_o |-> (mem_req_o && !mem_we_o));

    a_r8_hold_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_clk_hold_o |-> mem_req_o);

    a_r9_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_ad_oe_o |-> !$past(mcu_rdstb_n_i));

    a_r9_no_drive_while_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_ad_oe_o |-> !mcu_clk_hold_o);
endmodule

bind mcu_ram_bridge mcu_ram_bridge_chk #(.WIN_BASE(WIN_BASE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mcu_rdstb_n_i  (mcu_rdstb_n_i),
    .mcu_ad_oe_o    (mcu_ad_oe_o),
    .mcu_clk_hold_o (mcu_clk_hold_o),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .mem_we_o       (mem_we_o),
    .mem_ack_i      (mem_ack_i),
    .mem_abort_o    (mem_abort_o)
);

// File: tb/mcu_ram_bridge_tb.sv
module mcu_ram_bridge_tb;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_mode = 1'b0;
    logic        ale = 1'b0, fetch_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  hi = '0, ad = '0;
    logic [7:0]  ad_o;
    logic        ad_oe, hold, req, we, ack = 1'b0, busy = 1'b0, abort;
    logic [15:0] maddr;
    logic [7:0]  wdata, rdata = '0;
    logic [15:0] wr_addr_seen = '0;
    logic [7:0]  wr_data_seen = '0;
    int          cnt = 0;
    int          nchk = 0, nfail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    mcu_ram_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .fast_mode_i(fast_mode),
        .mcu_alatch_i(ale), .mcu_fetch_n_i(fetch_n), .mcu_rdstb_n_i(rd_n),
        .mcu_wrstb_n_i(wr_n), .mcu_addr_hi_i(hi), .mcu_ad_i(ad),
        .mcu_ad_o(ad_o), .mcu_ad_oe_o(ad_oe), .mcu_clk_hold_o(hold),
        .mem_req_o(req), .mem_addr_o(maddr), .mem_we_o(we), .mem_wdata_o(wdata),
        .mem_rdata_i(rdata), .mem_ack_i(ack), .mem_other_busy_i(busy),
        .mem_abort_o(abort)
    );

    // memory model: acknowledges after LAT cycles of request
    always @(posedge clk) begin
        if (req && !ack) begin
            if (cnt == LAT - 1) begin
                ack   <= 1'b1;
                rdata <= maddr[7:0] ^ 8'h5A;
                cnt   <= 0;
                if (we) begin
                    wr_addr_seen <= maddr;
                    wr_data_seen <= wdata;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            ack <= 1'b0;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [15:0] a);
        @(negedge clk);
        ale = 1'b1; hi = a[15:8]; ad = a[7:0];
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_ack();
        int n = 0;
        while (!ack && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (n >= 50) chk("ack timeout", 0, 1);
        @(negedge clk);
    endtask

    task automatic idle_strobes();
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; fetch_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 req", req, 0);
        chk("R1 abort", abort, 0);
        chk("R1 hold", hold, 0);
        chk("R1 oe", ad_oe, 0);
    endtask

    task automatic t_fast_low();
        bit seen = 0;
        fast_mode = 1'b1;
        addr_phase(16'h1234);
        chk("R3 no req low addr", req, 0);
        fetch_n = 1'b0; rd_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            if (req || hold || ad_oe) seen = 1;
        end
        chk("R3 fetch not served", seen, 0);
        idle_strobes();
    endtask

    task automatic t_fast_read();
        fast_mode = 1'b1; busy = 1'b0;
        addr_phase(16'hC123);
        chk("R4 req on latch", req, 1);
        chk("R4 read flag", we, 0);
        chk("R2 address", maddr, 16'hC123);
        chk("R5 no abort when free", abort, 0);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R8 hold during eager read", hold, 1);
        wait_ack();
        chk("R8 hold released", hold, 0);
        chk("R9 oe", ad_oe, 1);
        chk("R9 data", ad_o, 8'h23 ^ 8'h5A);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R9 oe off", ad_oe, 0);
        idle_strobes();
    endtask

    task automatic t_fast_abort();
        bit seen = 0;
        fast_mode = 1'b1; busy = 1'b1;
        addr_phase(16'hD000);
        busy = 1'b0;
        chk("R5 abort with req", {abort, req}, 2'b11);
        @(negedge clk);
        chk("R5 abort one cycle", abort, 0);
        repeat (8) begin
            @(negedge clk);
            if (hold) seen = 1;
        end
        chk("R11 no hold without strobe", seen, 0);
        addr_phase(16'h0100);
        fetch_n = 1'b0; rd_n = 1'b0;
        seen = 0;
        repeat (4) begin
            @(negedge clk);
            if (ad_oe || req) seen = 1;
        end
        chk("R11 byte discarded", seen, 0);
        idle_strobes();
    endtask

    task automatic t_fast_prefetch();
        bit seen = 0;
        fast_mode = 1'b1;
        addr_phase(16'hC0F0);
        wait_ack();
        repeat (2) @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R4 buffered byte driven", {ad_oe, ad_o}, {1'b1, 8'hF0 ^ 8'h5A});
        if (req || hold) seen = 1;
        chk("R4 no new request", seen, 0);
        rd_n = 1'b1;
        idle_strobes();
    endtask

    task automatic t_fast_write();
        fast_mode = 1'b1;
        addr_phase(16'hC010);
        ad = 8'h77; wr_n = 1'b0;
        @(negedge clk);
        chk("R8 hold on eager write", hold, 1);
        wait_ack();
        chk("R10 chained write", {req, we, wdata}, {1'b1, 1'b1, 8'h77});
        chk("R8 hold kept", hold, 1);
        wait_ack();
        chk("R8 hold dropped", hold, 0);
        chk("R10 mem saw write", {wr_addr_seen, wr_data_seen}, {16'hC010, 8'h77});
        idle_strobes();
    endtask

    task automatic t_slow_read();
        fast_mode = 1'b0;
        addr_phase(16'hE055);
        chk("R6 no req on latch", req, 0);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R6 req on read", {req, we}, 2'b10);
        chk("R8 hold", hold, 1);
        wait_ack();
        chk("R9 slow data", {ad_oe, ad_o, hold}, {1'b1, 8'h55 ^ 8'h5A, 1'b0});
        rd_n = 1'b1;
        @(negedge clk);
        chk("R9 slow oe off", ad_oe, 0);
        idle_strobes();
    endtask

    task automatic t_slow_fetch();
        bit seen = 0;
        fast_mode = 1'b0;
        addr_phase(16'hE000);
        fetch_n = 1'b0; rd_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            if (req || hold) seen = 1;
        end
        chk("R7 fetch low no req", seen, 0);
        idle_strobes();
    endtask

    task automatic t_slow_low();
        bit seen = 0;
        fast_mode = 1'b0;
        addr_phase(16'h4000);
        rd_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            if (req || hold) seen = 1;
        end
        chk("R6 below window no req", seen, 0);
        idle_strobes();
    endtask

    task automatic t_slow_write();
        fast_mode = 1'b0;
        addr_phase(16'hF0AA);
        ad = 8'h3C; wr_n = 1'b0;
        @(negedge clk);
        ad = 8'h00;
        chk("R10 write request", {req, we, wdata, hold}, {1'b1, 1'b1, 8'h3C, 1'b1});
        wait_ack();
        chk("R8 write hold off", hold, 0);
        chk("R10 mem write", {wr_addr_seen, wr_data_seen}, {16'hF0AA, 8'h3C});
        idle_strobes();
    endtask

    task automatic t_mode_change();
        fast_mode = 1'b1;
        addr_phase(16'hC0AB);
        wait_ack();
        fast_mode = 1'b0;
        repeat (2) @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R12 pending access ends eagerly", {ad_oe, req, ad_o}, {1'b1, 1'b0, 8'hAB ^ 8'h5A});
        rd_n = 1'b1;
        idle_strobes();
        addr_phase(16'hC0CD);
        chk("R12 new mode after idle", req, 0);
        idle_strobes();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast_low();
        t_fast_read();
        t_fast_abort();
        t_fast_prefetch();
        t_fast_write();
        t_slow_read();
        t_slow_fetch();
        t_slow_low();
        t_slow_write();
        t_mode_change();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule